// File: doc/BRIEF.md
# CPU System Register Bank

This block keeps the control and status registers of a small RISC core: saved PC/PSW pairs for maskable interrupts, non-maskable interrupts, table calls and debug traps, a cause code register, the program status word and a table-call base pointer. Software reaches the registers through a 5-bit register number. A write port carries load-to-system-register accesses and a read port carries store-from-system-register accesses. Accesses are filtered by number. The cause register is read-only to software. The debug-trap pair is reachable only while a debug trap runs. Reserved numbers are inert.

Two hardware strobes record the core state on interrupt and NMI entry. Each one overwrites the single save pair it owns. Three return-address outputs feed the core's return path, and each drives bit 0 as zero whatever software stored there.

Top module: `sysreg_bank`

## Requirements
- R1: The register numbers are 0 interrupt PC, 1 interrupt PSW, 2 NMI PC, 3 NMI PSW, 4 cause, 5 PSW, 16 table-call PC, 17 table-call PSW, 18 debug PC, 19 debug PSW and 20 table-call base. A software write to a writable number is returned by a later read of that number.
- R2: A software write takes effect at the rising clock edge after `wr_en_i` is set. A read is combinational: before that edge the read port still shows the old value.
- R3: A software write to number 4 (cause) leaves its contents unchanged. Reads of number 4 work.
- R4: Numbers 18 and 19 are accessible only while `dbg_active_i` is 1. At other times, writes to them are dropped and reads return 0.
- R5: Numbers 6 to 15 and 21 to 31 are reserved. Writes to them change no register. Reads of them return 0, and `rd_illegal_o` is 1 in every cycle where `rd_en_i` is 1 and `rd_num_i` is reserved. Otherwise `rd_illegal_o` is 0.
- R6: `irq_save_i` loads register 0 from `cur_pc_i`, register 1 from `cur_psw_i`, and cause bits [15:0] from `cause_code_i`. Cause bits [31:16] keep their value.
- R7: `nmi_save_i` loads register 2 from `cur_pc_i`, register 3 from `cur_psw_i`, and cause bits [31:16] from `cause_code_i`. Cause bits [15:0] keep their value.
- R8: When a hardware save and a software write target the same register in the same cycle, the hardware value is stored. A save overwrites the previous pair, and no earlier value is kept.
- R9: `irq_ret_pc_o`, `nmi_ret_pc_o` and `tcall_ret_pc_o` show registers 0, 2 and 16 with bit 0 forced to 0.
- R10: Reset (`rst_ni` low) clears every register to 0, except the PSW, which becomes 32'h0000_0020 (bit 5, interrupt disable, set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_num_i | input | 5 | Register number for the write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Software read strobe, qualifies `rd_illegal_o` |
| rd_num_i | input | 5 | Register number for the read |
| rd_data_o | output | 32 | Read data, combinational |
| rd_illegal_o | output | 1 | Read of a reserved number |
| dbg_active_i | input | 1 | Debug trap is executing |
| irq_save_i | input | 1 | Interrupt entry save strobe |
| nmi_save_i | input | 1 | NMI entry save strobe |
| cur_pc_i | input | 32 | PC to save |
| cur_psw_i | input | 32 | PSW to save |
| cause_code_i | input | 16 | Cause code to save |
| irq_ret_pc_o | output | 32 | Interrupt return address, bit 0 zero |
| nmi_ret_pc_o | output | 32 | NMI return address, bit 0 zero |
| tcall_ret_pc_o | output | 32 | Table-call return address, bit 0 zero |

## Verification
A hardware entry save and a software write can land in the same cycle on the same register. The bench provokes this by raising `irq_save_i` while writing number 0, and `nmi_save_i` while writing number 3. It also raises both strobes together so that the two halves of the cause register update at once. The bench judges the result by reading back every number and comparing it with a model in which the saved core state wins, the cause halves merge, and the software value is lost.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int NUM_W  = 5;
  localparam int NSLOT  = 11;
  localparam int SLOT_W = $clog2(NSLOT);

  typedef enum logic [NUM_W-1:0] {
    N_IPC   = 5'd0,
    N_IPSW  = 5'd1,
    N_NPC   = 5'd2,
    N_NPSW  = 5'd3,
    N_CAUSE = 5'd4,
    N_PSW   = 5'd5,
    N_TPC   = 5'd16,
    N_TPSW  = 5'd17,
    N_DPC   = 5'd18,
    N_DPSW  = 5'd19,
    N_TBASE = 5'd20
  } sr_num_e;

  // storage slot indices
  localparam logic [SLOT_W-1:0] S_IPC   = 4'd0;
  localparam logic [SLOT_W-1:0] S_IPSW  = 4'd1;
  localparam logic [SLOT_W-1:0] S_NPC   = 4'd2;
  localparam logic [SLOT_W-1:0] S_NPSW  = 4'd3;
  localparam logic [SLOT_W-1:0] S_CAUSE = 4'd4;
  localparam logic [SLOT_W-1:0] S_PSW   = 4'd5;
  localparam logic [SLOT_W-1:0] S_TPC   = 4'd6;
  localparam logic [SLOT_W-1:0] S_TPSW  = 4'd7;
  localparam logic [SLOT_W-1:0] S_DPC   = 4'd8;
  localparam logic [SLOT_W-1:0] S_DPSW  = 4'd9;
  localparam logic [SLOT_W-1:0] S_TBASE = 4'd10;
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
(
  input  logic [NUM_W-1:0]  num_i,
  input  logic              dbg_active_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              present_o,
  output logic              visible_o
);
  logic dbg_only;

  always_comb begin
    slot_o    = S_IPC;
    present_o = 1'b1;
    dbg_only  = 1'b0;
    case (sr_num_e'(num_i))
      N_IPC:   slot_o = S_IPC;
      N_IPSW:  slot_o = S_IPSW;
      N_NPC:   slot_o = S_NPC;
      N_NPSW:  slot_o = S_NPSW;
      N_CAUSE: slot_o = S_CAUSE;
      N_PSW:   slot_o = S_PSW;
      N_TPC:   slot_o = S_TPC;
      N_TPSW:  slot_o = S_TPSW;
      N_DPC:   begin slot_o = S_DPC;  dbg_only = 1'b1; end
      N_DPSW:  begin slot_o = S_DPSW; dbg_only = 1'b1; end
      N_TBASE: slot_o = S_TBASE;
      default: present_o = 1'b0;
    endcase
    visible_o = present_o && (!dbg_only || dbg_active_i);
  end
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
  import sysreg_pkg::*;
#(
  parameter int                XLEN    = 32,
  parameter logic [XLEN-1:0]   PSW_RST = 32'h0000_0020
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic [SLOT_W-1:0] sw_slot_i,
  input  logic [XLEN-1:0]   sw_d_i,
  input  logic [NSLOT-1:0]  hw_we_i,
  input  logic [XLEN-1:0]   hw_d_i [NSLOT],
  output logic [XLEN-1:0]   q_o    [NSLOT]
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [XLEN-1:0] RST_V = (g == int'(S_PSW)) ? PSW_RST : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       q_o[g] <= RST_V;
      else if (hw_we_i[g])                               q_o[g] <= hw_d_i[g];
      else if (sw_we_i && (sw_slot_i == SLOT_W'(g)))     q_o[g] <= sw_d_i;
    end
  end
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] PSW_RST = 32'h0000_0020
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [NUM_W-1:0]   wr_num_i,
  input  logic [XLEN-1:0]    wr_data_i,
  input  logic               rd_en_i,
  input  logic [NUM_W-1:0]   rd_num_i,
  output logic [XLEN-1:0]    rd_data_o,
  output logic               rd_illegal_o,
  input  logic               dbg_active_i,
  input  logic               irq_save_i,
  input  logic               nmi_save_i,
  input  logic [XLEN-1:0]    cur_pc_i,
  input  logic [XLEN-1:0]    cur_psw_i,
  input  logic [XLEN/2-1:0]  cause_code_i,
  output logic [XLEN-1:0]    irq_ret_pc_o,
  output logic [XLEN-1:0]    nmi_ret_pc_o,
  output logic [XLEN-1:0]    tcall_ret_pc_o
);
  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] EVEN_MASK = ~XLEN'(1);

  logic [SLOT_W-1:0] w_slot, r_slot;
  logic              w_present, w_vis, r_present, r_vis;
  logic              sw_we;
  logic [NSLOT-1:0]  hw_we;
  logic [XLEN-1:0]   hw_d [NSLOT];
  logic [XLEN-1:0]   q    [NSLOT];

  sysreg_decode u_wdec (
    .num_i(wr_num_i), .dbg_active_i(dbg_active_i),
    .slot_o(w_slot), .present_o(w_present), .visible_o(w_vis)
  );

  sysreg_decode u_rdec (
    .num_i(rd_num_i), .dbg_active_i(dbg_active_i),
    .slot_o(r_slot), .present_o(r_present), .visible_o(r_vis)
  );

  // cause register is read-only to software
  assign sw_we = wr_en_i && w_present && w_vis && (w_slot != S_CAUSE);

  always_comb begin
    hw_we = '0;
    for (int i = 0; i < NSLOT; i++) hw_d[i] = '0;
    if (irq_save_i) begin
      hw_we[S_IPC]  = 1'b1;  hw_d[S_IPC]  = cur_pc_i;
      hw_we[S_IPSW] = 1'b1;  hw_d[S_IPSW] = cur_psw_i;
    end
    if (nmi_save_i) begin
      hw_we[S_NPC]  = 1'b1;  hw_d[S_NPC]  = cur_pc_i;
      hw_we[S_NPSW] = 1'b1;  hw_d[S_NPSW] = cur_psw_i;
    end
    // each strobe owns one half of the cause word
    hw_we[S_CAUSE] = irq_save_i | nmi_save_i;
    hw_d[S_CAUSE]  = {nmi_save_i ? cause_code_i : q[S_CAUSE][XLEN-1:HALF],
                      irq_save_i ? cause_code_i : q[S_CAUSE][HALF-1:0]};
  end

  sysreg_file #(.XLEN(XLEN), .PSW_RST(PSW_RST)) u_file (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sw_we_i(sw_we), .sw_slot_i(w_slot), .sw_d_i(wr_data_i),
    .hw_we_i(hw_we), .hw_d_i(hw_d), .q_o(q)
  );

  assign rd_data_o      = (r_present && r_vis) ? q[r_slot] : '0;
  assign rd_illegal_o   = rd_en_i && !r_present;
  assign irq_ret_pc_o   = q[S_IPC] & EVEN_MASK;
  assign nmi_ret_pc_o   = q[S_NPC] & EVEN_MASK;
  assign tcall_ret_pc_o = q[S_TPC] & EVEN_MASK;
endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [4:0]      wr_num_i,
  input logic [XLEN-1:0] wr_data_i,
  input logic            rd_en_i,
  input logic [4:0]      rd_num_i,
  input logic [XLEN-1:0] rd_data_o,
  input logic            rd_illegal_o,
  input logic            dbg_active_i,
  input logic            irq_save_i,
  input logic            nmi_save_i,
  input logic [XLEN-1:0] cur_pc_i,
  input logic [XLEN-1:0] irq_ret_pc_o,
  input logic [XLEN-1:0] nmi_ret_pc_o
);
  logic rsvd_rd;
  assign rsvd_rd = (rd_num_i > 5'd5 && rd_num_i < 5'd16) || rd_num_i > 5'd20;

  AST_RSVD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rsvd_rd) |-> (rd_data_o == '0 && rd_illegal_o));  // R5

  AST_NO_ILLEGAL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i || !rsvd_rd) |-> !rd_illegal_o);  // R5

  AST_DBG_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_active_i && (rd_num_i == 5'd18 || rd_num_i == 5'd19)) |-> rd_data_o == '0);  // R4

  AST_IRQ_SAVE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_save_i |=> irq_ret_pc_o == {$past(cur_pc_i[XLEN-1:1]), 1'b0});  // R8

  AST_NMI_SW_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_num_i == 5'd2 && !nmi_save_i) |=>
      nmi_ret_pc_o == {$past(wr_data_i[XLEN-1:1]), 1'b0});  // R2
endmodule

bind sysreg_bank sysreg_bank_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/sysreg_bank_tb.sv
module sysreg_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 0, rd_en_i = 0, dbg_active_i = 0, irq_save_i = 0, nmi_save_i = 0;
  logic [4:0]  wr_num_i = '0, rd_num_i = '0;
  logic [31:0] wr_data_i = '0, cur_pc_i = '0, cur_psw_i = '0;
  logic [15:0] cause_code_i = '0;
  logic [31:0] rd_data_o, irq_ret_pc_o, nmi_ret_pc_o, tcall_ret_pc_o;
  logic        rd_illegal_o;

  int checks = 0, errors = 0;
  logic [31:0] model [32];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sysreg_bank dut_i (.*);

  function automatic bit is_rsvd(int n);
    return (n > 5 && n < 16) || n > 20;
  endfunction

  function automatic logic [31:0] exp_rd(int n, bit dbg);
    if (is_rsvd(n)) return '0;
    if ((n == 18 || n == 19) && !dbg) return '0;
    return model[n];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(int n, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1; wr_num_i = 5'(n); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
    if (!is_rsvd(n) && n != 4 && (!(n == 18 || n == 19) || dbg_active_i)) model[n] = d;
  endtask

  task automatic read_all(string req);
    for (int n = 0; n < 32; n++) begin
      rd_en_i = 1; rd_num_i = 5'(n); #1;
      chk(req, rd_data_o, exp_rd(n, dbg_active_i));
      chk("R5 illegal flag", {31'd0, rd_illegal_o}, {31'd0, is_rsvd(n)});
    end
    rd_en_i = 0; #1;
    chk("R5 idle flag", {31'd0, rd_illegal_o}, 32'd0);
  endtask

  task automatic chk_ret(string req);
    chk({req, " irq ret"},   irq_ret_pc_o,   model[0]  & ~32'd1);
    chk({req, " nmi ret"},   nmi_ret_pc_o,   model[2]  & ~32'd1);
    chk({req, " tcall ret"}, tcall_ret_pc_o, model[16] & ~32'd1);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    model[5] = 32'h0000_0020;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R10 reset state, debug visible so 18/19 are read too
    dbg_active_i = 1;
    read_all("R10 reset value");
    chk_ret("R10");

    // R2 old value visible until the edge
    @(negedge clk_i);
    wr_en_i = 1; wr_num_i = 5'd20; wr_data_i = 32'h1234_5678;
    rd_num_i = 5'd20; #1;
    chk("R2 before edge", rd_data_o, 32'h0);
    @(posedge clk_i); #1;
    chk("R2 after edge", rd_data_o, 32'h1234_5678);
    @(negedge clk_i); wr_en_i = 0;
    model[20] = 32'h1234_5678;

    // R1 R3 R4 R5 sweep of every number, debug low then high
    for (int pass = 0; pass < 2; pass++) begin
      dbg_active_i = pass[0];
      for (int n = 0; n < 32; n++)
        sw_write(n, 32'hA500_0001 ^ (n << 8) ^ (pass << 20));
      read_all(pass == 0 ? "R1 R3 R4 sweep dbg low" : "R1 R3 R4 sweep dbg high");
      chk_ret("R9");
    end

    // R6 R8 irq save collides with software write to number 0
    @(negedge clk_i);
    irq_save_i = 1; cur_pc_i = 32'h0000_4003; cur_psw_i = 32'h0000_00A7; cause_code_i = 16'h0080;
    wr_en_i = 1; wr_num_i = 5'd0; wr_data_i = 32'hDEAD_BEEF;
    @(negedge clk_i);
    irq_save_i = 0; wr_en_i = 0;
    model[0] = 32'h0000_4003; model[1] = 32'h0000_00A7;
    model[4] = {model[4][31:16], 16'h0080};
    read_all("R6 R8 irq save");
    chk_ret("R9 after irq save");

    // R7 R8 nmi save collides with software write to number 3
    @(negedge clk_i);
    nmi_save_i = 1; cur_pc_i = 32'h0000_8005; cur_psw_i = 32'h0000_0031; cause_code_i = 16'h0010;
    wr_en_i = 1; wr_num_i = 5'd3; wr_data_i = 32'hCAFE_0000;
    @(negedge clk_i);
    nmi_save_i = 0; wr_en_i = 0;
    model[2] = 32'h0000_8005; model[3] = 32'h0000_0031;
    model[4] = {16'h0010, model[4][15:0]};
    read_all("R7 R8 nmi save");

    // R6 R7 R8 both strobes at once, single copy overwritten
    @(negedge clk_i);
    irq_save_i = 1; nmi_save_i = 1;
    cur_pc_i = 32'h0000_C001; cur_psw_i = 32'h0000_0055; cause_code_i = 16'h00C0;
    @(negedge clk_i);
    irq_save_i = 0; nmi_save_i = 0;
    model[0] = 32'h0000_C001; model[1] = 32'h0000_0055;
    model[2] = 32'h0000_C001; model[3] = 32'h0000_0055;
    model[4] = {16'h00C0, 16'h00C0};
    read_all("R6 R7 R8 dual save");
    chk_ret("R9 after dual save");

    // R10 reset again clears everything
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
    for (int i = 0; i < 32; i++) model[i] = '0;
    model[5] = 32'h0000_0020;
    read_all("R10 second reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule